// File: doc/BRIEF.md
# Periodic Counter-Correction Clock Trimmer

This block turns an oscillator tick of nominally 32768 Hz into a corrected once-per-second tick. It divides in two stages: a chunk prescaler, 256 oscillator ticks per chunk by default, and a chunk counter, 128 chunks per second by default. Accuracy is trimmed digitally. In selected seconds the block either splits one chunk into two counts or stretches one chunk by half its length, so that second is shorter or longer than nominal.

A signed trim setting drives the correction: a 5-bit magnitude and a direction bit. The block keeps its own position in a repeating cycle of 64 minutes. It learns where each minute starts from a level input that the downstream timekeeper holds high while the second being counted is the first one of a minute. With magnitude n, the first second of each of the first 2·n minutes of the cycle is altered, so one step of magnitude is worth two altered seconds per cycle. A separate free-running square wave at 1/64 of the oscillator rate, 512 Hz by default, is provided for frequency measurement. No trim setting affects it.

Top module: `cal_trim`

## Requirements
- R1: While reset is asserted and right after it, `tick_1hz` and `ft_out` are 0, and the cycle position, the prescaler and the chunk counter start at zero.
- R2: A second that is not corrected ends after exactly 2^(CHUNK_W+CHUNKS_W) oscillator ticks. `tick_1hz` is a one-cycle pulse in the clock cycle after the oscillator tick that completes the second.
- R3: A corrected second with `cal_dir`=1 (speed up) is shorter than nominal by exactly one chunk (2^CHUNK_W ticks), because the first chunk of that second is counted twice.
- R4: A corrected second with `cal_dir`=0 (slow down) is longer than nominal by exactly half a chunk (2^(CHUNK_W-1) ticks), because the first chunk of that second is stretched.
- R5: The cycle position is a counter modulo 2^CYC_W. It advances only with a `tick_1hz` that ends a second during which `first_sec` was high. A second is corrected only when `first_sec` is high and position < 2·`cal_mag`.
- R6: With `cal_mag`=0, no second is ever altered, whatever the value of `cal_dir`.
- R7: Over one full cycle of 2^CYC_W minutes, the total oscillator tick count equals the nominal total, minus 2·n chunks for speed-up or plus 2·n half-chunks for slow-down. With n=31, 62 minutes are altered.
- R8: `ft_out` is bit FT_W-1 of a free-running count of oscillator ticks. It toggles every 2^(FT_W-1) ticks and is unaffected by `cal_mag`, `cal_dir` and `first_sec`.
- R9: In a cycle where `osc_tick` is low, nothing advances: no `tick_1hz` follows and `ft_out` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| cal_mag | input | MAG_W | Trim magnitude, 0 to 31 by default |
| cal_dir | input | 1 | 1 = speed up (split), 0 = slow down (stretch) |
| first_sec | input | 1 | High while the second being counted is the first of a minute |
| tick_1hz | output | 1 | One-cycle pulse at the end of each corrected second |
| ft_out | output | 1 | Untrimmed frequency-test square wave |

## Verification
The bench builds the block with CHUNK_W=3, CHUNKS_W=2 and FT_W=2. A nominal second is then 32 oscillator ticks and a correction moves it by 8 or 4 ticks. The bench plays minutes of four seconds, so a whole 64-minute cycle takes about eight thousand oscillator ticks. These sizes let several complete cycles run: magnitudes 0, 1, 6 and 31 with both directions, and oscillator patterns with and without idle cycles. The wrap of the cycle position and the 62-minute limit are therefore exercised in full.

// File: rtl/cal_trim_pkg.sv
package cal_trim_pkg;
  typedef enum logic [1:0] {
    TRIM_NONE    = 2'd0,
    TRIM_SPLIT   = 2'd1,
    TRIM_STRETCH = 2'd2
  } trim_e;
endpackage

// File: rtl/cal_sched.sv
module cal_sched import cal_trim_pkg::*; #(
  parameter int MAG_W = 5,
  parameter int CYC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_end,
  input  logic             first_sec,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_dir,
  output trim_e            mode,
  output logic [CYC_W-1:0] cyc_pos
);
  localparam int CW = (MAG_W + 1 > CYC_W) ? MAG_W + 1 : CYC_W;

  logic [CYC_W-1:0] pos_q, pos_d;
  logic [CW-1:0]    span, pos_ext;
  logic             hit;

  always_comb begin
    span    = CW'({cal_mag, 1'b0});
    pos_ext = CW'(pos_q);
    hit     = first_sec && (cal_mag != '0) && (pos_ext < span);
    if (!hit)        mode = TRIM_NONE;
    else if (cal_dir) mode = TRIM_SPLIT;
    else             mode = TRIM_STRETCH;
  end

  always_comb begin
    pos_d = pos_q;
    if (sec_end && first_sec) pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign cyc_pos = pos_q;
endmodule

// File: rtl/cal_chunk.sv
module cal_chunk import cal_trim_pkg::*; #(
  parameter int CHUNK_W = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  osc_tick,
  input  trim_e mode,
  input  logic  in_first_chunk,
  output logic  chunk_pulse
);
  localparam int CNT_W = CHUNK_W + 1;
  localparam logic [CNT_W-1:0] LIM_N   = CNT_W'((1 << CHUNK_W) - 1);
  localparam logic [CNT_W-1:0] LIM_S   = CNT_W'((1 << CHUNK_W) + (1 << (CHUNK_W - 1)) - 1);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'((1 << (CHUNK_W - 1)) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             at_end, mid;

  always_comb begin
    lim    = (mode == TRIM_STRETCH && in_first_chunk) ? LIM_S : LIM_N;
    at_end = (cnt_q >= lim);
    mid    = (mode == TRIM_SPLIT) && in_first_chunk && (cnt_q == HALF_M1);
    chunk_pulse = osc_tick && (at_end || mid);
    cnt_d = cnt_q;
    if (osc_tick) cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cal_second.sv
module cal_second #(
  parameter int CHUNKS_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chunk_pulse,
  output logic in_first_chunk,
  output logic sec_end
);
  logic [CHUNKS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    in_first_chunk = (cnt_q == '0);
    sec_end        = chunk_pulse && (&cnt_q);
    cnt_d          = chunk_pulse ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cal_ftgen.sv
module cal_ftgen #(
  parameter int FT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  output logic ft_out
);
  logic [FT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = osc_tick ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ft_out = cnt_q[FT_W-1];
endmodule

// File: rtl/cal_trim.sv
module cal_trim import cal_trim_pkg::*; #(
  parameter int CHUNK_W  = 8,
  parameter int CHUNKS_W = 7,
  parameter int MAG_W    = 5,
  parameter int CYC_W    = 6,
  parameter int FT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_dir,
  input  logic             first_sec,
  output logic             tick_1hz,
  output logic             ft_out
);
  logic [1:0]       rs_q;
  logic             rst_n_s;
  trim_e            mode;
  logic [CYC_W-1:0] cyc_pos;
  logic             chunk_pulse, in_first_chunk, sec_end;
  logic             tick_q, tick_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  cal_sched #(.MAG_W(MAG_W), .CYC_W(CYC_W)) u_sched (
    .clk(clk), .rst_n(rst_n_s), .sec_end(sec_end), .first_sec(first_sec),
    .cal_mag(cal_mag), .cal_dir(cal_dir), .mode(mode), .cyc_pos(cyc_pos)
  );

  cal_chunk #(.CHUNK_W(CHUNK_W)) u_chunk (
    .clk(clk), .rst_n(rst_n_s), .osc_tick(osc_tick), .mode(mode),
    .in_first_chunk(in_first_chunk), .chunk_pulse(chunk_pulse)
  );

  cal_second #(.CHUNKS_W(CHUNKS_W)) u_second (
    .clk(clk), .rst_n(rst_n_s), .chunk_pulse(chunk_pulse),
    .in_first_chunk(in_first_chunk), .sec_end(sec_end)
  );

  cal_ftgen #(.FT_W(FT_W)) u_ft (
    .clk(clk), .rst_n(rst_n_s), .osc_tick(osc_tick), .ft_out(ft_out)
  );

  always_comb tick_d = sec_end;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) tick_q <= 1'b0;
    else          tick_q <= tick_d;
  end
  assign tick_1hz = tick_q;
endmodule

// File: rtl/cal_trim_chk.sv
module cal_trim_chk #(
  parameter int CYC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_tick,
  input logic             first_sec,
  input logic             tick_1hz,
  input logic             ft_out,
  input logic [CYC_W-1:0] cyc_pos
);
  AST_TICK_AFTER_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> $past(osc_tick)); // R9

  AST_FT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> $stable(ft_out)); // R8

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> !tick_1hz); // R2

  AST_POS_ON_MINUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cyc_pos) |-> (tick_1hz && $past(first_sec))); // R5

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!tick_1hz && !ft_out); // R1
  end
endmodule

bind cal_trim cal_trim_chk #(.CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .first_sec(first_sec),
  .tick_1hz(tick_1hz), .ft_out(ft_out), .cyc_pos(cyc_pos)
);

// File: tb/test_cal_trim.sv
module test_cal_trim;
  localparam int CHUNK_W  = 3;
  localparam int CHUNKS_W = 2;
  localparam int MAG_W    = 5;
  localparam int CYC_W    = 6;
  localparam int FT_W     = 2;
  localparam int CHUNK    = 1 << CHUNK_W;
  localparam int NOM      = 1 << (CHUNK_W + CHUNKS_W);
  localparam int SPM      = 4;             // seconds per bench minute
  localparam int MINS     = 1 << CYC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic [MAG_W-1:0] cal_mag = '0;
  logic cal_dir = 1'b0;
  logic first_sec = 1'b0;
  logic tick_1hz, ft_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cal_trim #(.CHUNK_W(CHUNK_W), .CHUNKS_W(CHUNKS_W), .MAG_W(MAG_W),
             .CYC_W(CYC_W), .FT_W(FT_W)) i_cal_trim (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cal_mag(cal_mag),
    .cal_dir(cal_dir), .first_sec(first_sec), .tick_1hz(tick_1hz), .ft_out(ft_out)
  );

  // behavioural reference
  int m_cnt, m_s, m_min, m_ft, m_osc, m_ticks, m_osc_at_cycle;
  logic exp_tick, exp_ft, last_osc;
  string cur_tag;
  bit cmp_en = 0;

  function automatic int sec_len(int s, int mn);
    int l = NOM;
    if (s == 0 && cal_mag != 0 && (mn % MINS) < 2 * cal_mag)
      l = cal_dir ? NOM - CHUNK : NOM + CHUNK / 2;
    return l;
  endfunction

  function automatic string tag_for(int s, int mn);
    if (cal_mag == 0) return "R6";
    if (sec_len(s, mn) < NOM) return "R3";
    if (sec_len(s, mn) > NOM) return "R4";
    if (s == 0) return "R5";
    return "R2";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_s = 0; m_min = 0; m_ft = 0; m_osc = 0; m_ticks = 0;
      m_osc_at_cycle = -1; exp_tick = 0; exp_ft = 0; last_osc = 0;
    end else begin
      exp_tick = 0;
      last_osc = osc_tick;
      cur_tag = tag_for(m_s, m_min);
      if (osc_tick) begin
        m_ft++; m_osc++; m_cnt++;
        if (m_cnt == sec_len(m_s, m_min)) begin
          exp_tick = 1; m_cnt = 0; m_ticks++;
          if (m_s == 0) m_min++;
          m_s = (m_s + 1) % SPM;
          if (m_ticks == MINS * SPM) m_osc_at_cycle = m_osc;
        end
      end
      exp_ft = ((m_ft >> (FT_W - 1)) & 1) != 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      total++;
      if (tick_1hz !== exp_tick) begin
        bad++;
        $display("FAIL %s%s tick_1hz actual=%0b expected=%0b minute=%0d",
                 cur_tag, last_osc ? "" : " R9", tick_1hz, exp_tick, m_min);
      end
      total++;
      if (ft_out !== exp_ft) begin
        bad++;
        $display("FAIL R8 ft_out actual=%0b expected=%0b", ft_out, exp_ft);
      end
    end
  end

  task automatic run_setting(int mag, bit dir, int gap);
    int expect_total;
    int cyc = 0;
    @(negedge clk);
    cmp_en = 0; rst_n = 0; osc_tick = 0;
    cal_mag = MAG_W'(mag); cal_dir = dir;
    repeat (3) @(negedge clk);
    total++;
    if (tick_1hz !== 1'b0 || ft_out !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs actual=%0b%0b expected=00", tick_1hz, ft_out);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_en = 1;
    while (m_ticks < MINS * SPM) begin
      cyc++;
      osc_tick = (gap == 0) ? 1'b1 : ((cyc % gap) != 0);
      first_sec = (m_s == 0);
      @(negedge clk);
    end
    osc_tick = 0;
    repeat (3) @(negedge clk);
    if (mag == 0)    expect_total = NOM * MINS * SPM;
    else if (dir)    expect_total = NOM * MINS * SPM - 2 * mag * CHUNK;
    else             expect_total = NOM * MINS * SPM + 2 * mag * (CHUNK / 2);
    total++;
    if (m_osc_at_cycle != expect_total) begin
      bad++;
      $display("FAIL R7 cycle ticks mag=%0d dir=%0b actual=%0d expected=%0d",
               mag, dir, m_osc_at_cycle, expect_total);
    end
    cmp_en = 0;
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run_setting(0, 1'b1, 0);   // R6
    run_setting(0, 1'b0, 5);   // R6
    run_setting(1, 1'b1, 0);   // R3
    run_setting(6, 1'b0, 7);   // R4
    run_setting(31, 1'b1, 3);  // R3 R7
    run_setting(31, 1'b0, 0);  // R4 R7
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule